// File: doc/BRIEF.md
# Codec Register Bridge

The bridge gives a 32-bit memory-mapped host a path into a bank of 8-bit control registers that belong to an on-chip audio codec. The host does not address those registers directly. It writes a command word that carries an internal address, and optionally a byte to store together with a write-request flag. The result of a lookup comes back through a second host word. The register bank sits inside the bridge and holds its power-on values, its write-protection rules and its gaps. Its contents go out on a flat bus to the analog side.

Both kinds of access take several cycles. A write occupies the bridge for a fixed number of cycles, and a busy flag in the command word shows this. A read begins when the host changes only the address field. The returned byte is only trustworthy a fixed number of cycles later. The codec's interrupt summary line and its live status byte come in from outside the bridge and are reflected back to the host.

Top module: `codec_reg_bridge`

## Requirements
- R1: After reset the command word (host offset 0) reads 0x00000000, and the data word (host offset 4) reads the status byte in bits 7:0 with the interrupt level in bit 8.
- R2: The 36 internal registers (addresses 0..35) come out of reset with fixed values, among them address 1 = 0xC3, address 14 = 0x40, address 31 = 0x34 and address 34 = 0x1F.
- R3: A command word write with bit 16 set, made while not busy, takes the address from bits 14:8 and the data from bits 7:0. Bit 16 reads 1 from the next cycle on, and bits 14:8 and 7:0 read back the captured address and data.
- R4: A write finishes 4 cycles after capture. On that edge the register takes the data (when writable) and bit 16 reads 0 again.
- R5: A command word write while not busy restarts a read of the address in bits 14:8. Data word bits 7:0 keep the previous value through the 5th cycle and show the new register value from the 6th cycle on. While idle, the byte follows the addressed register.
- R6: Address 0 reads the live codec status byte and ignores writes.
- R7: Addresses 5, 28 and all addresses above 35 ignore writes and read 0x00.
- R8: A write request made while busy is dropped entirely, address included, and sets the sticky error bit 31 of the command word. A command word write with bit 31 = 1 and bit 16 = 0, made while not busy, clears it.
- R9: Data word bit 8 follows the codec interrupt input, and data word bits 31:9 read 0.
- R10: `ctrl_regs` carries register n in bits n*8+7:n*8. The slots of addresses 0, 5 and 28 are 0.
- R11: Host writes to any offset other than 0 have no effect, and reads of any offset other than 0 and 4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_off | input | 3 | Host byte offset (0 command word, 4 data word) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for `host_off` |
| codec_status | input | 8 | Live status byte reported at address 0 |
| codec_irq | input | 1 | Interrupt summary from the flag logic |
| ctrl_regs | output | 288 | All register contents, 8 bits per address |

## Verification
The bench looks at the read byte on the 5th and the 6th cycle after an address update. A bridge that settles early or late therefore shows up as a byte that changes too soon or too late. It counts the busy cycles of every write and reads the command word once the write completes. A bridge with a wrong write timer, or one that never releases busy, fails these checks.

It issues a second write request while the first is still pending. A design that accepts that request would show the wrong address and would store the second byte. A design that forgets to set the error bit would read back bit 31 as clear. Writes to the status address, the two gaps and addresses past the end are all followed by read-back and by a compare of the full register bus. An address decode that leaks therefore shows up as a changed register.

// File: rtl/codec_bridge_pkg.sv
`timescale 1ns/1ps
package codec_bridge_pkg;

  localparam int CB_NREG    = 36;
  localparam int CB_ADDR_W  = 7;
  localparam int CB_DATA_W  = 8;
  localparam int CB_WORD_W  = 32;
  localparam int CB_OFF_W   = 3;

  // host word layout
  localparam int CB_REQ_BIT  = 16;
  localparam int CB_ERR_BIT  = 31;
  localparam int CB_ADDR_LSB = 8;
  localparam int CB_IRQ_BIT  = 8;

  localparam logic [CB_OFF_W-1:0] CB_CMD_OFF  = 3'd0;
  localparam logic [CB_OFF_W-1:0] CB_DATA_OFF = 3'd4;

  localparam int CB_STATUS_ADDR = 0;
  localparam int CB_GAP_A       = 5;
  localparam int CB_GAP_B       = 28;

  // address holds a readable location
  function automatic logic cb_is_present(input int idx, input int nreg);
    return (idx >= 0) && (idx < nreg) && (idx != CB_GAP_A) && (idx != CB_GAP_B);
  endfunction

  // address holds a flop that the host may change
  function automatic logic cb_is_writable(input int idx, input int nreg);
    return cb_is_present(idx, nreg) && (idx != CB_STATUS_ADDR);
  endfunction

  // power-on content of each location
  function automatic logic [CB_DATA_W-1:0] cb_reset_value(input int idx);
    logic [CB_DATA_W-1:0] v;
    case (idx)
      1, 2:           v = 8'hC3;
      3, 6:           v = 8'h90;
      4:              v = 8'h98;
      7:              v = 8'hB1;
      8:              v = 8'h11;
      9:              v = 8'h10;
      11:             v = 8'h03;
      14:             v = 8'h40;
      16:             v = 8'hFF;
      18, 19, 20, 21: v = 8'h06;
      31:             v = 8'h34;
      32:             v = 8'h07;
      33:             v = 8'h44;
      34:             v = 8'h1F;
      default:        v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/cbr_cmd_ctrl.sv
`timescale 1ns/1ps
module cbr_cmd_ctrl
  import codec_bridge_pkg::*;
#(
  parameter int ADDR_W = CB_ADDR_W,
  parameter int DATA_W = CB_DATA_W,
  parameter int WORD_W = CB_WORD_W,
  parameter int WR_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              err,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              accept,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);

  localparam int WCNT_W = $clog2(WR_LAT + 1);

  logic              busy_q;
  logic              err_q;
  logic [WCNT_W-1:0] wcnt_q;
  logic              req;
  logic              start;
  logic              drop;
  logic              clr_err;

  wire unused_cmd_bits = ^{cmd_wdata[CB_ERR_BIT-1:CB_REQ_BIT+1],
                           cmd_wdata[CB_REQ_BIT-1:CB_ADDR_LSB+ADDR_W]};

  assign req     = cmd_wdata[CB_REQ_BIT];
  assign accept  = cmd_we && !busy_q;
  assign start   = accept && req;
  assign drop    = cmd_we && busy_q && req;
  assign clr_err = accept && !req && cmd_wdata[CB_ERR_BIT];
  assign commit  = busy_q && (wcnt_q == WCNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      wcnt_q <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (accept) addr_q <= cmd_wdata[CB_ADDR_LSB +: ADDR_W];
      if (start) begin
        data_q <= cmd_wdata[DATA_W-1:0];
        busy_q <= 1'b1;
        wcnt_q <= WCNT_W'(WR_LAT);
      end else if (busy_q) begin
        wcnt_q <= wcnt_q - WCNT_W'(1);
        if (commit) busy_q <= 1'b0;
      end
      if (drop) err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
    end
  end

  assign busy        = busy_q;
  assign err         = err_q;
  assign commit_addr = addr_q;
  assign commit_data = data_q;

endmodule

// File: rtl/cbr_regfile.sv
`timescale 1ns/1ps
module cbr_regfile
  import codec_bridge_pkg::*;
#(
  parameter int NREG   = CB_NREG,
  parameter int ADDR_W = CB_ADDR_W,
  parameter int DATA_W = CB_DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      waddr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NREG*DATA_W-1:0] regs_flat
);

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    if (cb_is_writable(g, NREG)) begin : g_rw
      localparam logic [DATA_W-1:0] RST_V = DATA_W'(cb_reset_value(g));
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_V;
        else if (we && (waddr == ADDR_W'(g))) q <= wdata;
      end
      assign regs_flat[g*DATA_W +: DATA_W] = q;
    end else begin : g_hole
      assign regs_flat[g*DATA_W +: DATA_W] = '0;
    end
  end

endmodule

// File: rtl/cbr_rd_settle.sv
`timescale 1ns/1ps
module cbr_rd_settle #(
  parameter int DATA_W = 8,
  parameter int RD_LAT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [DATA_W-1:0] lookup,
  output logic [DATA_W-1:0] rd_q,
  output logic              load
);

  localparam int CNT_W = $clog2(RD_LAT + 1);

  logic [CNT_W-1:0] cnt_q;

  // the held byte refreshes only once the settle window has run out
  assign load = (cnt_q < CNT_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rd_q  <= '0;
    end else begin
      if (restart) cnt_q <= CNT_W'(RD_LAT);
      else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
      if (load) rd_q <= lookup;
    end
  end

endmodule

// File: rtl/codec_reg_bridge.sv
`timescale 1ns/1ps
module codec_reg_bridge
  import codec_bridge_pkg::*;
#(
  parameter int NREG   = CB_NREG,
  parameter int ADDR_W = CB_ADDR_W,
  parameter int DATA_W = CB_DATA_W,
  parameter int WORD_W = CB_WORD_W,
  parameter int OFF_W  = CB_OFF_W,
  parameter int WR_LAT = 4,
  parameter int RD_LAT = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   host_we,
  input  logic [OFF_W-1:0]       host_off,
  input  logic [WORD_W-1:0]      host_wdata,
  output logic [WORD_W-1:0]      host_rdata,
  input  logic [DATA_W-1:0]      codec_status,
  input  logic                   codec_irq,
  output logic [NREG*DATA_W-1:0] ctrl_regs
);

  localparam int IDX_W = $clog2(NREG);

  // named internal events, also used by the bound checker
  logic              cmd_we;
  logic              busy;
  logic              err;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;
  logic              commit;
  logic [ADDR_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;
  logic [DATA_W-1:0] lookup;
  logic [DATA_W-1:0] rd_q;
  logic              rd_load;
  logic [NREG*DATA_W-1:0] regs_flat;
  logic [DATA_W-1:0] reg_view [NREG];

  assign cmd_we = host_we && (host_off == OFF_W'(CB_CMD_OFF));

  cbr_cmd_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W), .WR_LAT(WR_LAT)
  ) u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_wdata  (host_wdata),
    .busy       (busy),
    .err        (err),
    .addr_q     (addr_q),
    .data_q     (data_q),
    .accept     (accept),
    .commit     (commit),
    .commit_addr(commit_addr),
    .commit_data(commit_data)
  );

  cbr_regfile #(
    .NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (commit),
    .waddr    (commit_addr),
    .wdata    (commit_data),
    .regs_flat(regs_flat)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign reg_view[g] = regs_flat[g*DATA_W +: DATA_W];
  end

  // byte seen by a read of the current address
  function automatic logic [DATA_W-1:0] pick_byte(
    input logic [ADDR_W-1:0] a,
    input logic [DATA_W-1:0] status,
    input logic [DATA_W-1:0] stored
  );
    if (int'(a) == CB_STATUS_ADDR) return status;
    if (cb_is_present(int'(a), NREG)) return stored;
    return '0;
  endfunction

  assign lookup = pick_byte(addr_q, codec_status, reg_view[addr_q[IDX_W-1:0]]);

  cbr_rd_settle #(
    .DATA_W(DATA_W), .RD_LAT(RD_LAT)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(accept),
    .lookup (lookup),
    .rd_q   (rd_q),
    .load   (rd_load)
  );

  always_comb begin
    host_rdata = '0;
    if (host_off == OFF_W'(CB_CMD_OFF)) begin
      host_rdata[CB_ERR_BIT]                 = err;
      host_rdata[CB_REQ_BIT]                 = busy;
      host_rdata[CB_ADDR_LSB +: ADDR_W]      = addr_q;
      host_rdata[DATA_W-1:0]                 = data_q;
    end else if (host_off == OFF_W'(CB_DATA_OFF)) begin
      host_rdata[CB_IRQ_BIT]                 = codec_irq;
      host_rdata[DATA_W-1:0]                 = rd_q;
    end
  end

  assign ctrl_regs = regs_flat;

endmodule

// File: rtl/codec_reg_bridge_chk.sv
`timescale 1ns/1ps
module codec_reg_bridge_chk
  import codec_bridge_pkg::*;
#(
  parameter int NREG   = CB_NREG,
  parameter int ADDR_W = CB_ADDR_W,
  parameter int DATA_W = CB_DATA_W,
  parameter int WORD_W = CB_WORD_W,
  parameter int OFF_W  = CB_OFF_W,
  parameter int WR_LAT = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   host_we,
  input logic [OFF_W-1:0]       host_off,
  input logic [WORD_W-1:0]      host_wdata,
  input logic                   busy,
  input logic                   err,
  input logic                   commit,
  input logic [ADDR_W-1:0]      commit_addr,
  input logic                   rd_load,
  input logic [ADDR_W-1:0]      addr_q,
  input logic [DATA_W-1:0]      rd_q,
  input logic [NREG*DATA_W-1:0] ctrl_regs
);

  logic req_to_cmd;
  logic [7:0] busy_run;

  assign req_to_cmd = host_we && (host_off == OFF_W'(CB_CMD_OFF)) && host_wdata[CB_REQ_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= '0;
    else if (!busy) busy_run <= '0;
    else if (busy_run != 8'hFF) busy_run <= busy_run + 8'd1;
  end

  // R3: accepted write request raises busy
  a_r3_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
    req_to_cmd && !busy |=> busy);

  // R4: commit releases the bridge on the next cycle
  a_r4_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

  // R4: busy never lasts longer than the write time
  a_r4_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= 8'(WR_LAT));

  // R8: a request while busy flags the error
  a_r8_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    req_to_cmd && busy |=> err);

  // R6 R7: commits to protected addresses leave the register bus unchanged
  a_r7_protected: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !cb_is_writable(int'(commit_addr), NREG) |=> $stable(ctrl_regs));

  // R7: loads from absent addresses deliver zero
  a_r7_absent_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load && (addr_q != '0) && !cb_is_present(int'(addr_q), NREG) |=> rd_q == '0);

  // R5: the returned byte is held while the settle window runs
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_load |=> $stable(rd_q));

endmodule

bind codec_reg_bridge codec_reg_bridge_chk #(
  .NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .WORD_W(WORD_W), .OFF_W(OFF_W), .WR_LAT(WR_LAT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_we    (host_we),
  .host_off   (host_off),
  .host_wdata (host_wdata),
  .busy       (busy),
  .err        (err),
  .commit     (commit),
  .commit_addr(commit_addr),
  .rd_load    (rd_load),
  .addr_q     (addr_q),
  .rd_q       (rd_q),
  .ctrl_regs  (ctrl_regs)
);

// File: tb/codec_reg_bridge_tb.sv
`timescale 1ns/1ps
module codec_reg_bridge_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         host_we = 1'b0;
  logic [2:0]   host_off;
  logic [31:0]  host_wdata = '0;
  logic [31:0]  host_rdata;
  logic [7:0]   codec_status = 8'h5A;
  logic         codec_irq = 1'b0;
  logic [287:0] ctrl_regs;

  logic [2:0] drv_off = 3'd0;
  logic [2:0] mon_off = 3'd0;
  logic       mon_act = 1'b0;
  assign host_off = mon_act ? mon_off : drv_off;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] last_rd;

  logic [7:0] model [36] = '{
    8'h00, 8'hC3, 8'hC3, 8'h90, 8'h98, 8'h00, 8'h90, 8'hB1,
    8'h11, 8'h10, 8'h00, 8'h03, 8'h00, 8'h00, 8'h40, 8'h00,
    8'hFF, 8'h00, 8'h06, 8'h06, 8'h06, 8'h06, 8'h00, 8'h00,
    8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h34,
    8'h07, 8'h44, 8'h1F, 8'h00};

  typedef struct {
    int          due;
    logic [2:0]  off;
    logic [31:0] mask;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  codec_reg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_off(host_off),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .codec_status(codec_status), .codec_irq(codec_irq), .ctrl_regs(ctrl_regs));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit tb_writable(input int a);
    return a > 0 && a < 36 && a != 5 && a != 28;
  endfunction

  function automatic logic [7:0] tb_expect(input int a);
    if (a == 0) return codec_status;
    if (tb_writable(a)) return model[a];
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int due, input logic [2:0] off, input logic [31:0] mask,
                      input logic [31:0] exp, input string tag);
    item_t it;
    it.due = due; it.off = off; it.mask = mask; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares scoreboard items on their due cycle, away from the edge
  always begin
    @(posedge clk);
    #1;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      mon_off = it.off;
      mon_act = 1'b1;
      #0.1;
      check((host_rdata & it.mask) == it.exp, it.tag, host_rdata & it.mask, it.exp);
      mon_act = 1'b0;
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_write(input logic [2:0] off, input logic [31:0] w, output int n0);
    @(negedge clk);
    drv_off = off;
    host_wdata = w;
    host_we = 1'b1;
    n0 = cyc + 1;
    @(negedge clk);
    host_we = 1'b0;
    drv_off = 3'd0;
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    int n0;
    host_write(3'd0, {1'b0, 14'b0, 1'b1, 1'b0, 7'(a), d}, n0);
    push(n0, 3'd0, 32'h0001_0000, 32'h0001_0000, "R3 busy after request");
    push(n0 + 3, 3'd0, 32'h0001_0000, 32'h0001_0000, "R4 busy through 4th cycle");
    push(n0 + 4, 3'd0, 32'h0001_7FFF, {15'b0, 1'b0, 1'b0, 7'(a), d}, "R4 busy clear R3 fields");
    if (tb_writable(a)) model[a] = d;
    wait_cycles(9);
    last_rd = tb_expect(a);
  endtask

  task automatic do_read(input int a, input string tag);
    int n0;
    logic [7:0] e;
    host_write(3'd0, {1'b0, 14'b0, 1'b0, 1'b0, 7'(a), 8'h00}, n0);
    e = tb_expect(a);
    push(n0 + 5, 3'd4, 32'h0000_00FF, {24'b0, last_rd}, "R5 old byte held at 5th cycle");
    push(n0 + 6, 3'd4, 32'h0000_00FF, {24'b0, e}, tag);
    push(n0 + 9, 3'd4, 32'h0000_00FF, {24'b0, e}, tag);
    wait_cycles(10);
    last_rd = e;
  endtask

  task automatic check_bus(input string tag);
    int bad = -1;
    for (int i = 0; i < 36; i++)
      if (ctrl_regs[i*8 +: 8] !== model[i] && bad < 0) bad = i;
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, tag, {24'b0, ctrl_regs[bad*8 +: 8]}, {24'b0, model[bad]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n0;
    wait_cycles(5);
    rst_n = 1'b1;
    wait_cycles(3);

    // R1 reset state
    drv_off = 3'd0; #0.1;
    check(host_rdata == 32'h0, "R1 command word after reset", host_rdata, 32'h0);
    drv_off = 3'd4; #0.1;
    check(host_rdata == 32'h0000_005A, "R1 data word after reset", host_rdata, 32'h0000_005A);
    drv_off = 3'd0;
    last_rd = 8'h5A;

    // R2 R10 defaults on the register bus
    check_bus("R10 R2 register bus defaults");

    // R2 defaults through reads
    do_read(1, "R2 default addr 1");
    do_read(31, "R2 default addr 31");
    do_read(34, "R2 default addr 34");
    do_read(14, "R2 default addr 14");

    // R3 R4 write and read back
    do_write(10, 8'hA5);
    do_read(10, "R3 written byte read back");
    do_write(33, 8'h5C);
    do_read(1, "R5 new address after write");
    do_read(33, "R4 second write stored");
    check_bus("R10 register bus after writes");

    // R6 status address
    do_write(0, 8'h33);
    do_read(0, "R6 status address ignores write");
    @(negedge clk);
    codec_status = 8'hC7;
    wait_cycles(2);
    drv_off = 3'd4; #0.1;
    check(host_rdata[7:0] == 8'hC7, "R6 status byte live", host_rdata, 32'hC7);
    drv_off = 3'd0;
    last_rd = 8'hC7;

    // R7 gaps and out of range
    do_write(5, 8'h77);
    do_read(5, "R7 gap 5 reads zero");
    do_write(28, 8'h66);
    do_read(28, "R7 gap 28 reads zero");
    do_write(40, 8'h99);
    do_read(40, "R7 out of range reads zero");
    check_bus("R7 register bus unchanged by protected writes");

    // R8 request while busy
    host_write(3'd0, {1'b0, 14'b0, 1'b1, 1'b0, 7'd12, 8'h11}, n0);
    push(n0, 3'd0, 32'h0001_0000, 32'h0001_0000, "R8 first request busy");
    host_write(3'd0, {1'b0, 14'b0, 1'b1, 1'b0, 7'd13, 8'h22}, n0);
    push(n0, 3'd0, 32'h8000_7F00, 32'h8000_0C00, "R8 dropped request sets error keeps address");
    model[12] = 8'h11;
    wait_cycles(8);
    last_rd = model[12];
    do_read(13, "R8 dropped byte not stored");
    do_read(12, "R8 first byte stored");
    drv_off = 3'd0; #0.1;
    check(host_rdata[31] == 1'b1, "R8 error sticky", host_rdata, 32'h8000_0000);
    host_write(3'd0, {1'b1, 14'b0, 1'b0, 1'b0, 7'd12, 8'h00}, n0);
    push(n0, 3'd0, 32'h8000_0000, 32'h0, "R8 error cleared");
    wait_cycles(8);
    last_rd = model[12];

    // R9 interrupt bit
    @(negedge clk);
    codec_irq = 1'b1;
    drv_off = 3'd4; #0.1;
    check(host_rdata == {23'b0, 1'b1, model[12]}, "R9 irq high", host_rdata, {23'b0, 1'b1, model[12]});
    codec_irq = 1'b0; #0.1;
    check(host_rdata == {23'b0, 1'b0, model[12]}, "R9 irq low", host_rdata, {23'b0, 1'b0, model[12]});
    drv_off = 3'd0;

    // R11 other offsets
    host_write(3'd4, 32'h0001_0A55, n0);
    drv_off = 3'd0; #0.1;
    check((host_rdata & 32'h8001_7FFF) == 32'h0000_0C11, "R11 write to data word ignored",
          host_rdata, 32'h0000_0C11);
    wait_cycles(6);
    check_bus("R11 register bus unchanged");
    drv_off = 3'd2; #0.1;
    check(host_rdata == 32'h0, "R11 unused offset reads zero", host_rdata, 32'h0);
    drv_off = 3'd0;

    while (sb.size() != 0) @(negedge clk);
    wait_cycles(2);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule